// File: doc/BRIEF.md
# Fatal/Nonfatal Interrupt Aggregation Controller

This block gathers the interrupt conditions of a script-driven bus controller. For each raised condition it decides whether the condition stops the script engine or is only recorded. The conditions come in two groups. The DMA group is always fatal. The SCSI group is split across two status registers. A SCSI source is fatal or nonfatal depending on its enable bit and on whether the controller acts as initiator or target.

Each status register latches source pulses and clears when the host reads it. Two summary flags report which group has something pending. When the first fatal condition appears while the engine runs, a one-cycle halt request goes to the sequencer. An active-low interrupt pin signals fatal conditions. A control bit can hide them at the pin without dropping them. A DMA-FIFO-empty level passes through untouched, because raising an interrupt does not flush any FIFO and software checks that level itself.

Top module: `irq_fatal_agg`

## Requirements
- R1: A pulse on a source bit sets the matching status bit on the next clock edge. The bit holds until a read strobe for that register, after which it reads zero on the following cycle.
- R2: When a source bit pulses in the same cycle as the read strobe of its register, that bit stays set after the read.
- R3: Any set DMA status bit raises `dma_pend` and counts as fatal, whatever the DMA enable register holds. It therefore drives `irq_n` low (pin mask clear) and can request a halt.
- R4: `scsi_pend` is high exactly when any bit of either SCSI status register is set.
- R5: In initiator role (`role_init`=1), SCSI zero bits 0, 1, 2 (function complete, selected, reselected) and SCSI one bits 0, 1 (general-purpose timer, handshake-to-handshake timer) are nonfatal. A pending nonfatal bit whose enable is clear affects neither `irq_n` nor `halt_req`.
- R6: In target role (`role_init`=0), only SCSI zero bit 0 and SCSI one bit 1 are nonfatal. Every other SCSI bit is fatal.
- R7: Setting the enable bit of a nonfatal source makes it fatal. Enable registers are written from `wdata` by their write strobes and read back on their outputs.
- R8: A control write (`we_ctl`) loads the pin mask from `wdata` bit 1. While the mask is set, `irq_n` stays high and status keeps latching.
- R9: A control write that clears the mask while a fatal condition is pending drives `irq_n` low in that same cycle.
- R10: `halt_req` is high for exactly one cycle, when a fatal condition is pending, `seq_running` is high and the request is armed. Issuing it disarms the request. It re-arms only after `seq_running` has been seen low.
- R11: `dma_fifo_empty_o` follows `dma_fifo_empty_i` and no interrupt changes it.
- R12: After synchronous reset, all status, enable and mask registers are zero, `irq_n` is high and `halt_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_init | input | 1 | 1 = initiator role, 0 = target role |
| seq_running | input | 1 | Sequencer reports script execution |
| dma_src | input | 8 | DMA-group condition pulses |
| s0_src | input | 8 | SCSI group zero condition pulses |
| s1_src | input | 8 | SCSI group one condition pulses |
| rd_dma | input | 1 | Host read of DMA status (clears it) |
| rd_s0 | input | 1 | Host read of SCSI zero status |
| rd_s1 | input | 1 | Host read of SCSI one status |
| we_dma_en | input | 1 | Write DMA enable register |
| we_s0_en | input | 1 | Write SCSI zero enable register |
| we_s1_en | input | 1 | Write SCSI one enable register |
| we_ctl | input | 1 | Write control register (pin mask in bit 1) |
| wdata | input | 8 | Host write data |
| dma_fifo_empty_i | input | 1 | DMA FIFO empty level |
| dma_stat | output | 8 | DMA status register |
| s0_stat | output | 8 | SCSI zero status register |
| s1_stat | output | 8 | SCSI one status register |
| dma_en | output | 8 | DMA enable register |
| s0_en | output | 8 | SCSI zero enable register |
| s1_en | output | 8 | SCSI one enable register |
| pin_mask | output | 1 | Stored pin mask bit |
| dma_pend | output | 1 | DMA summary pending |
| scsi_pend | output | 1 | SCSI summary pending |
| halt_req | output | 1 | One-cycle halt request to sequencer |
| irq_n | output | 1 | Active-low interrupt pin |
| dma_fifo_empty_o | output | 1 | DMA FIFO empty level for software |

## Verification
The properties assume the host issues at most one control write per cycle. They also assume `seq_running` is a clean level that the sequencer drops after a halt. The stimulus keeps to that by driving every input from one task between clock edges and by toggling `seq_running` only as a level. Random source pulses are sparse, with reads mixed in, so status bits both accumulate and clear. Directed steps cover the same-cycle read/source race, the role switch, re-arming after the engine restarts and unmasking in the write cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic {
        ROLE_TARGET    = 1'b0,
        ROLE_INITIATOR = 1'b1
    } role_e;

    // Summary of one status group after classification
    typedef struct packed {
        logic pend;
        logic fatal;
    } grp_sum_t;

    localparam int unsigned CTL_PIN_MASK_BIT = 1;

    function automatic role_e to_role(input logic init_bit);
        return init_bit ? ROLE_INITIATOR : ROLE_TARGET;
    endfunction

endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src,
    input  logic         rd,
    output logic [W-1:0] stat
);
    logic [W-1:0] kept;

    // A read empties the register; a pulse in the same cycle survives
    assign kept = rd ? '0 : stat;

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= kept | src;
    end
endmodule

// File: rtl/irq_grp_class.sv
module irq_grp_class
    import irq_agg_pkg::*;
#(
    parameter int           W       = 8,
    parameter logic [W-1:0] NF_INIT = '0,
    parameter logic [W-1:0] NF_TGT  = '0
) (
    input  logic [W-1:0] stat,
    input  logic [W-1:0] en,
    input  role_e        role,
    output grp_sum_t     sum
);
    logic [W-1:0] nonfatal;
    logic [W-1:0] fatal_bits;

    assign nonfatal   = (role == ROLE_INITIATOR) ? NF_INIT : NF_TGT;
    // Fatal when not in the nonfatal set, or promoted by its enable
    assign fatal_bits = stat & (~nonfatal | en);

    assign sum.pend  = |stat;
    assign sum.fatal = |fatal_bits;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int DMA_W    = 8,
    parameter int S0_W     = 8,
    parameter int S1_W     = 8,
    parameter int DATA_W   = 8,
    parameter int MASK_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_dma_en,
    input  logic              we_s0_en,
    input  logic              we_s1_en,
    input  logic              we_ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DMA_W-1:0]  dma_en,
    output logic [S0_W-1:0]   s0_en,
    output logic [S1_W-1:0]   s1_en,
    output logic              mask_q,
    output logic              mask_eff
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dma_en <= '0;
            s0_en  <= '0;
            s1_en  <= '0;
            mask_q <= 1'b0;
        end else begin
            if (we_dma_en) dma_en <= wdata[DMA_W-1:0];
            if (we_s0_en)  s0_en  <= wdata[S0_W-1:0];
            if (we_s1_en)  s1_en  <= wdata[S1_W-1:0];
            if (we_ctl)    mask_q <= wdata[MASK_BIT];
        end
    end

    // The value being written takes effect at the pin in the write cycle
    assign mask_eff = we_ctl ? wdata[MASK_BIT] : mask_q;
endmodule

// File: rtl/irq_halt_ctl.sv
module irq_halt_ctl (
    input  logic clk,
    input  logic rst,
    input  logic fatal_any,
    input  logic seq_running,
    output logic halt_req
);
    logic armed_q;

    assign halt_req = armed_q & seq_running & fatal_any;

    always_ff @(posedge clk) begin
        if (rst)               armed_q <= 1'b1;
        else if (halt_req)     armed_q <= 1'b0;
        else if (!seq_running) armed_q <= 1'b1;
    end
endmodule

// File: rtl/irq_fatal_agg.sv
module irq_fatal_agg
    import irq_agg_pkg::*;
#(
    parameter int                DMA_W      = 8,
    parameter int                S0_W       = 8,
    parameter int                S1_W       = 8,
    parameter int                DATA_W     = 8,
    parameter logic [S0_W-1:0]   S0_NF_INIT = 'h07,
    parameter logic [S1_W-1:0]   S1_NF_INIT = 'h03,
    parameter logic [S0_W-1:0]   S0_NF_TGT  = 'h01,
    parameter logic [S1_W-1:0]   S1_NF_TGT  = 'h02
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              role_init,
    input  logic              seq_running,
    input  logic [DMA_W-1:0]  dma_src,
    input  logic [S0_W-1:0]   s0_src,
    input  logic [S1_W-1:0]   s1_src,
    input  logic              rd_dma,
    input  logic              rd_s0,
    input  logic              rd_s1,
    input  logic              we_dma_en,
    input  logic              we_s0_en,
    input  logic              we_s1_en,
    input  logic              we_ctl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dma_fifo_empty_i,
    output logic [DMA_W-1:0]  dma_stat,
    output logic [S0_W-1:0]   s0_stat,
    output logic [S1_W-1:0]   s1_stat,
    output logic [DMA_W-1:0]  dma_en,
    output logic [S0_W-1:0]   s0_en,
    output logic [S1_W-1:0]   s1_en,
    output logic              pin_mask,
    output logic              dma_pend,
    output logic              scsi_pend,
    output logic              halt_req,
    output logic              irq_n,
    output logic              dma_fifo_empty_o
);
    localparam logic [DMA_W-1:0] DMA_NF = '0;  // no DMA source is nonfatal

    role_e    role;
    grp_sum_t dma_sum, s0_sum, s1_sum;
    logic     mask_eff;
    logic     fatal_any;

    assign role = to_role(role_init);

    irq_stat_bank #(.W(DMA_W)) u_dma_bank (
        .clk(clk), .rst(rst), .src(dma_src), .rd(rd_dma), .stat(dma_stat)
    );
    irq_stat_bank #(.W(S0_W)) u_s0_bank (
        .clk(clk), .rst(rst), .src(s0_src), .rd(rd_s0), .stat(s0_stat)
    );
    irq_stat_bank #(.W(S1_W)) u_s1_bank (
        .clk(clk), .rst(rst), .src(s1_src), .rd(rd_s1), .stat(s1_stat)
    );

    irq_cfg_regs #(
        .DMA_W(DMA_W), .S0_W(S0_W), .S1_W(S1_W), .DATA_W(DATA_W),
        .MASK_BIT(CTL_PIN_MASK_BIT)
    ) u_cfg (
        .clk(clk), .rst(rst),
        .we_dma_en(we_dma_en), .we_s0_en(we_s0_en), .we_s1_en(we_s1_en),
        .we_ctl(we_ctl), .wdata(wdata),
        .dma_en(dma_en), .s0_en(s0_en), .s1_en(s1_en),
        .mask_q(pin_mask), .mask_eff(mask_eff)
    );

    irq_grp_class #(.W(DMA_W), .NF_INIT(DMA_NF), .NF_TGT(DMA_NF)) u_dma_cls (
        .stat(dma_stat), .en(dma_en), .role(role), .sum(dma_sum)
    );
    irq_grp_class #(.W(S0_W), .NF_INIT(S0_NF_INIT), .NF_TGT(S0_NF_TGT)) u_s0_cls (
        .stat(s0_stat), .en(s0_en), .role(role), .sum(s0_sum)
    );
    irq_grp_class #(.W(S1_W), .NF_INIT(S1_NF_INIT), .NF_TGT(S1_NF_TGT)) u_s1_cls (
        .stat(s1_stat), .en(s1_en), .role(role), .sum(s1_sum)
    );

    assign dma_pend  = dma_sum.pend;
    assign scsi_pend = s0_sum.pend | s1_sum.pend;
    assign fatal_any = dma_sum.fatal | s0_sum.fatal | s1_sum.fatal;

    irq_halt_ctl u_halt (
        .clk(clk), .rst(rst), .fatal_any(fatal_any),
        .seq_running(seq_running), .halt_req(halt_req)
    );

    assign irq_n            = ~(fatal_any & ~mask_eff);
    assign dma_fifo_empty_o = dma_fifo_empty_i;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int DMA_W    = 8,
    parameter int S0_W     = 8,
    parameter int S1_W     = 8,
    parameter int DATA_W   = 8,
    parameter int MASK_BIT = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              seq_running,
    input logic [DMA_W-1:0]  dma_src,
    input logic [S0_W-1:0]   s0_src,
    input logic              rd_dma,
    input logic              rd_s0,
    input logic              we_ctl,
    input logic [DATA_W-1:0] wdata,
    input logic [DMA_W-1:0]  dma_stat,
    input logic [S0_W-1:0]   s0_stat,
    input logic              pin_mask,
    input logic              dma_pend,
    input logic              scsi_pend,
    input logic              halt_req,
    input logic              irq_n
);
    assert_clear_on_read_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_dma && dma_src == '0) |=> (dma_stat == '0));

    assert_src_wins_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_s0 && (|s0_src)) |=> ((s0_stat & $past(s0_src)) == $past(s0_src)));

    assert_dma_pend_R3: assert property (@(posedge clk) disable iff (rst)
        (|dma_src) |=> dma_pend);

    assert_dma_fatal_pin_R3: assert property (@(posedge clk) disable iff (rst)
        ((|dma_stat) && !pin_mask && !we_ctl) |-> !irq_n);

    assert_scsi_pend_R4: assert property (@(posedge clk) disable iff (rst)
        (|s0_src) |=> scsi_pend);

    assert_pin_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (pin_mask && !we_ctl) |-> irq_n);

    assert_unmask_now_R9: assert property (@(posedge clk) disable iff (rst)
        (we_ctl && !wdata[MASK_BIT] && (|dma_stat)) |-> !irq_n);

    assert_halt_single_R10: assert property (@(posedge clk) disable iff (rst)
        halt_req |=> !halt_req);

    assert_halt_running_R10: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> seq_running);
endmodule

bind irq_fatal_agg irq_agg_chk #(
    .DMA_W(DMA_W), .S0_W(S0_W), .S1_W(S1_W), .DATA_W(DATA_W), .MASK_BIT(1)
) u_chk (
    .clk(clk), .rst(rst), .seq_running(seq_running),
    .dma_src(dma_src), .s0_src(s0_src), .rd_dma(rd_dma), .rd_s0(rd_s0),
    .we_ctl(we_ctl), .wdata(wdata), .dma_stat(dma_stat), .s0_stat(s0_stat),
    .pin_mask(pin_mask), .dma_pend(dma_pend), .scsi_pend(scsi_pend),
    .halt_req(halt_req), .irq_n(irq_n)
);

// File: tb/irq_fatal_agg_tb.sv
`timescale 1ns/1ps
module irq_fatal_agg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       role_init = 1'b1, seq_running = 1'b1;
    logic [7:0] dma_src = '0, s0_src = '0, s1_src = '0;
    logic       rd_dma = 0, rd_s0 = 0, rd_s1 = 0;
    logic       we_dma_en = 0, we_s0_en = 0, we_s1_en = 0, we_ctl = 0;
    logic [7:0] wdata = '0;
    logic       fifo_in = 1'b1;
    logic [7:0] dma_stat, s0_stat, s1_stat, dma_en, s0_en, s1_en;
    logic       pin_mask, dma_pend, scsi_pend, halt_req, irq_n, fifo_out;

    int n_chk = 0;
    int n_fail = 0;

    // model state
    logic [7:0] m_dma = '0, m_s0 = '0, m_s1 = '0;
    logic [7:0] m_den = '0, m_s0en = '0, m_s1en = '0;
    logic       m_mask = 1'b0, m_armed = 1'b1;

    always #2.5 clk = ~clk;

    irq_fatal_agg u_dut (
        .clk(clk), .rst(rst), .role_init(role_init), .seq_running(seq_running),
        .dma_src(dma_src), .s0_src(s0_src), .s1_src(s1_src),
        .rd_dma(rd_dma), .rd_s0(rd_s0), .rd_s1(rd_s1),
        .we_dma_en(we_dma_en), .we_s0_en(we_s0_en), .we_s1_en(we_s1_en),
        .we_ctl(we_ctl), .wdata(wdata), .dma_fifo_empty_i(fifo_in),
        .dma_stat(dma_stat), .s0_stat(s0_stat), .s1_stat(s1_stat),
        .dma_en(dma_en), .s0_en(s0_en), .s1_en(s1_en), .pin_mask(pin_mask),
        .dma_pend(dma_pend), .scsi_pend(scsi_pend), .halt_req(halt_req),
        .irq_n(irq_n), .dma_fifo_empty_o(fifo_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Nonfatal sets from R5 / R6
    function automatic logic [7:0] nf0();
        return role_init ? 8'h07 : 8'h01;
    endfunction
    function automatic logic [7:0] nf1();
        return role_init ? 8'h03 : 8'h02;
    endfunction
    function automatic logic exp_fatal();
        return (|m_dma) || (|(m_s0 & (~nf0() | m_s0en))) || (|(m_s1 & (~nf1() | m_s1en)));
    endfunction
    function automatic logic exp_irq_n();
        logic mk;
        mk = we_ctl ? wdata[1] : m_mask;
        return !(exp_fatal() && !mk);
    endfunction
    function automatic logic exp_halt();
        return m_armed && seq_running && exp_fatal();
    endfunction

    task automatic check_all();
        chk("R1 dma_stat", dma_stat, m_dma);
        chk("R1 s0_stat", s0_stat, m_s0);
        chk("R1 s1_stat", s1_stat, m_s1);
        chk("R3 dma_pend", dma_pend, |m_dma);
        chk("R4 scsi_pend", scsi_pend, (|m_s0) || (|m_s1));
        chk("R7 enables", {dma_en, s0_en, s1_en}, {m_den, m_s0en, m_s1en});
        chk("R8 pin_mask", pin_mask, m_mask);
        chk("R8 irq_n", irq_n, exp_irq_n());
        chk("R10 halt_req", halt_req, exp_halt());
        chk("R11 fifo", fifo_out, fifo_in);
    endtask

    task automatic model_update();
        logic h;
        h = exp_halt();
        m_dma = (rd_dma ? 8'h00 : m_dma) | dma_src;
        m_s0  = (rd_s0  ? 8'h00 : m_s0)  | s0_src;
        m_s1  = (rd_s1  ? 8'h00 : m_s1)  | s1_src;
        if (we_dma_en) m_den  = wdata;
        if (we_s0_en)  m_s0en = wdata;
        if (we_s1_en)  m_s1en = wdata;
        if (we_ctl)    m_mask = wdata[1];
        if (h) m_armed = 1'b0;
        else if (!seq_running) m_armed = 1'b1;
    endtask

    task automatic tick();
        #1;
        check_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
        dma_src = '0; s0_src = '0; s1_src = '0;
        rd_dma = 0; rd_s0 = 0; rd_s1 = 0;
        we_dma_en = 0; we_s0_en = 0; we_s1_en = 0; we_ctl = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c1a));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R12 reset state
        chk("R12 stat", {dma_stat, s0_stat, s1_stat}, 24'h0);
        chk("R12 en", {dma_en, s0_en, s1_en, pin_mask}, 25'h0);
        chk("R12 irq_n", irq_n, 1'b1);
        chk("R12 halt", halt_req, 1'b0);

        // R5: selected in initiator role, not enabled -> status only
        s0_src = 8'h02; tick();
        chk("R5 s0_stat", s0_stat, 8'h02);
        chk("R5 irq_n", irq_n, 1'b1);
        chk("R5 halt", halt_req, 1'b0);
        rd_s0 = 1; tick();
        chk("R1 clear on read", s0_stat, 8'h00);

        // R2: pulse in the read cycle survives
        s0_src = 8'h04; tick();
        s0_src = 8'h04; rd_s0 = 1; tick();
        chk("R2 src wins", s0_stat, 8'h04);
        rd_s0 = 1; tick();

        // R7: enable promotes selected to fatal
        we_s0_en = 1; wdata = 8'h02; tick();
        s0_src = 8'h02; tick();
        chk("R7 irq_n", irq_n, 1'b0);
        chk("R7 halt", halt_req, 1'b1);
        tick();
        chk("R10 single pulse", halt_req, 1'b0);
        s1_src = 8'h10; tick();
        chk("R10 no reissue", halt_req, 1'b0);
        seq_running = 0; tick();
        seq_running = 1; #1;
        chk("R10 rearmed", halt_req, 1'b1);
        tick();

        // R8 / R9 pin mask
        we_ctl = 1; wdata = 8'h02; tick();
        chk("R8 masked irq_n", irq_n, 1'b1);
        chk("R8 status kept", {s0_stat, s1_stat}, 16'h0210);
        we_ctl = 1; wdata = 8'h00; #1;
        chk("R9 unmask same cycle", irq_n, 1'b0);
        tick();
        rd_s0 = 1; rd_s1 = 1; tick();
        we_s0_en = 1; wdata = 8'h00; tick();

        // R6 target role
        role_init = 0; s0_src = 8'h02; tick();
        chk("R6 selected fatal in target", irq_n, 1'b0);
        rd_s0 = 1; tick();
        s1_src = 8'h02; tick();
        chk("R6 handshake nonfatal in target", irq_n, 1'b1);
        rd_s1 = 1; tick();
        role_init = 1;
        seq_running = 0; tick();
        seq_running = 1;

        // R3 DMA always fatal, R11 fifo level untouched
        we_dma_en = 1; wdata = 8'h00; tick();
        fifo_in = 0; dma_src = 8'h20; tick();
        chk("R3 dma_stat", dma_stat, 8'h20);
        chk("R3 dma_pend", dma_pend, 1'b1);
        chk("R3 irq_n", irq_n, 1'b0);
        chk("R11 fifo kept", fifo_out, 1'b0);
        rd_dma = 1; tick();

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 5 == 0) dma_src = 8'(1 << ($urandom % 8)) & ($urandom % 4 == 0 ? 8'hff : 8'h00);
            if ($urandom % 5 == 0) s0_src = 8'(1 << ($urandom % 8));
            if ($urandom % 5 == 0) s1_src = 8'(1 << ($urandom % 8));
            rd_dma = ($urandom % 5 == 0);
            rd_s0  = ($urandom % 5 == 0);
            rd_s1  = ($urandom % 5 == 0);
            wdata  = 8'($urandom);
            case ($urandom % 24)
                0: we_dma_en = 1;
                1: we_s0_en = 1;
                2: we_s1_en = 1;
                3, 4: we_ctl = 1;
                default: ;
            endcase
            if ($urandom % 150 == 0) role_init = ~role_init;
            if ($urandom % 9 == 0) seq_running = ~seq_running;
            if ($urandom % 7 == 0) fifo_in = ~fifo_in;
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule